// File: doc/BRIEF.md
# Pulse-Domain Multi-Point Observation Mux

This block models a test-access structure for logic in which every signal is a single-cycle pulse. Several internal nodes are tapped. Each tap is duplicated: one copy goes unchanged to the functional logic downstream, and the other copy is parked in its own destructive-readout cell. A per-point release strobe drives what would normally be that cell's clock pin. When the strobe fires, the parked pulse leaves the cell, and the cell is emptied.

The released pulses travel through a registered tree of two-input OR-style pulse mergers. The tree has one stage per level. At its root, one shared toggle stage turns each arriving pulse into a flip of an output level that slow equipment can watch. Strobing a single point therefore selects that point. A point that holds nothing contributes nothing.

A merger cannot represent two pulses that arrive together. In that case it emits one pulse and sets a sticky collision flag.

Top module: `obs_pulse_mux`

## Requirements
- R1: `node_out` equals `node_in` in every cycle, bit for bit, with no register delay.
- R2: A pulse on `node_in[i]` is stored in cell i. A strobe on `strobe[i]` sampled at clock edge e releases it, and `level_out` inverts at edge e + clog2(N_PTS) + 1 (edge e+3 for N_PTS=4).
- R3: Readout is destructive. A second strobe of the same point with no new arrival causes no change of `level_out`.
- R4: A strobe on a point whose cell is empty causes no change of `level_out`.
- R5: Several arrivals at a cell before its strobe are held as one pulse and produce exactly one inversion of `level_out`.
- R6: If an arrival and a strobe reach the same cell in the same cycle, the strobe releases the earlier content and the new arrival stays stored for the next strobe.
- R7: If two released pulses reach one merger in the same cycle, one pulse continues (one inversion) and `collide` goes to 1 and stays 1 until reset.
- R8: Pulses released from two points in different cycles each produce their own inversion, and `collide` stays 0.
- R9: Synchronous active-high `rst` clears all stored pulses, drives `level_out` to 0 and clears `collide`.
- R10: Strobing one point leaves the stored pulses of all other points intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_in | input | N_PTS | Tapped node pulses, one bit per observation point |
| strobe | input | N_PTS | Per-point release strobes |
| node_out | output | N_PTS | Functional copy of the tapped pulses |
| level_out | output | 1 | Observed level; inverts once per pulse at the tree root |
| collide | output | 1 | Sticky flag: coincident pulses met at a merger |

## Verification
Two kinds of event can fall in one cycle. The first is a fresh arrival at a cell together with that cell's release strobe. The bench drives both in one cycle and judges the result by the number of later inversions: one for the release, and one more after a second strobe. The second is two released pulses meeting at one merger. The bench provokes this by strobing two loaded points together, both siblings at the first tree level and cousins at the second. It expects exactly one inversion and a sticky `collide`. It contrasts this with the same two points strobed one cycle apart.

// File: rtl/obs_pkg.sv
package obs_pkg;
   // number of merger levels needed for n points (at least one)
   function automatic int unsigned tree_levels(input int unsigned n);
      int unsigned l;
      l = 0;
      while ((1 << l) < n) l++;
      return (l == 0) ? 1 : l;
   endfunction

   // total two-input mergers in a full tree over 2**lv leaves
   function automatic int unsigned merger_count(input int unsigned lv);
      return (1 << lv) - 1;
   endfunction
endpackage

// File: rtl/obs_split.sv
module obs_split #(
   parameter int unsigned N_PTS = 4
) (
   input  logic [N_PTS-1:0] tap_in,
   output logic [N_PTS-1:0] fwd,
   output logic [N_PTS-1:0] obs
);
   // each node feeds both the functional path and the observation path
   for (genvar i = 0; i < N_PTS; i++) begin : g_dup
      assign fwd[i] = tap_in[i];
      assign obs[i] = tap_in[i];
   end
endmodule

// File: rtl/obs_hold_cell.sv
module obs_hold_cell (
   input  logic clk,
   input  logic rst,
   input  logic pulse_in,
   input  logic strobe,
   output logic rel
);
   logic held;

   always_ff @(posedge clk) begin
      if (rst) begin
         held <= 1'b0;
         rel  <= 1'b0;
      end else begin
         rel  <= strobe & held;
         // a strobe empties the cell; an arrival in that same cycle is kept
         held <= strobe ? pulse_in : (held | pulse_in);
      end
   end

   AST_REL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      rel |-> $past(strobe)) else $error("release without strobe"); // R2
   AST_READ_DESTROYS: assert property (@(posedge clk) disable iff (rst)
      (strobe && !pulse_in) |=> !held) else $error("cell not emptied"); // R3
   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (held && !strobe) |=> held) else $error("stored pulse lost"); // R10
   AST_SAME_CYCLE_KEEP: assert property (@(posedge clk) disable iff (rst)
      (strobe && pulse_in) |=> held) else $error("coincident arrival lost"); // R6
endmodule

// File: rtl/obs_merge2.sv
module obs_merge2 (
   input  logic clk,
   input  logic rst,
   input  logic a,
   input  logic b,
   output logic y,
   output logic coll
);
   assign coll = a & b;

   always_ff @(posedge clk) begin
      if (rst) y <= 1'b0;
      else     y <= a | b;
   end

   AST_MERGE_PASS: assert property (@(posedge clk) disable iff (rst)
      (a || b) |=> y) else $error("merger dropped pulse"); // R8
   AST_MERGE_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!a && !b) |=> !y) else $error("merger invented pulse"); // R4
endmodule

// File: rtl/obs_merge_tree.sv
module obs_merge_tree
   import obs_pkg::*;
#(
   parameter int unsigned N_IN = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_IN-1:0] leaf,
   output logic            root,
   output logic            any_coll
);
   localparam int unsigned LVL = tree_levels(N_IN);
   localparam int unsigned W   = 1 << LVL;
   localparam int unsigned NM  = merger_count(LVL);

   logic [NM-1:0] coll_vec;

   for (genvar l = 0; l <= LVL; l++) begin : lv
      logic [(W>>l)-1:0] v;
      if (l == 0) begin : g_leaf
         if (W > N_IN) begin : g_pad
            assign v = {{(W-N_IN){1'b0}}, leaf};
         end else begin : g_nopad
            assign v = leaf;
         end
      end else begin : g_mrg
         for (genvar m = 0; m < (W>>l); m++) begin : g_m
            obs_merge2 u_m (
               .clk  (clk),
               .rst  (rst),
               .a    (lv[l-1].v[2*m]),
               .b    (lv[l-1].v[2*m+1]),
               .y    (v[m]),
               .coll (coll_vec[W - (W>>(l-1)) + m])
            );
         end
      end
   end

   assign root     = lv[LVL].v[0];
   assign any_coll = |coll_vec;
endmodule

// File: rtl/obs_p2l.sv
module obs_p2l (
   input  logic clk,
   input  logic rst,
   input  logic pulse,
   output logic level
);
   always_ff @(posedge clk) begin
      if (rst)        level <= 1'b0;
      else if (pulse) level <= ~level;
   end

   AST_TOGGLE_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
      pulse |=> (level != $past(level))) else $error("no toggle"); // R2
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
      !pulse |=> $stable(level)) else $error("spurious toggle"); // R4
endmodule

// File: rtl/obs_pulse_mux.sv
module obs_pulse_mux
   import obs_pkg::*;
#(
   parameter int unsigned N_PTS = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_PTS-1:0] node_in,
   input  logic [N_PTS-1:0] strobe,
   output logic [N_PTS-1:0] node_out,
   output logic             level_out,
   output logic             collide
);
   if (N_PTS < 2) begin : g_bad_n
      $error("obs_pulse_mux: N_PTS must be at least 2");
   end

   logic [N_PTS-1:0] obs_tap;
   logic [N_PTS-1:0] released;
   logic             root_pulse;
   logic             coll_now;

   obs_split #(.N_PTS(N_PTS)) u_split (
      .tap_in (node_in),
      .fwd    (node_out),
      .obs    (obs_tap)
   );

   for (genvar i = 0; i < N_PTS; i++) begin : g_cell
      obs_hold_cell u_cell (
         .clk      (clk),
         .rst      (rst),
         .pulse_in (obs_tap[i]),
         .strobe   (strobe[i]),
         .rel      (released[i])
      );
   end

   obs_merge_tree #(.N_IN(N_PTS)) u_tree (
      .clk      (clk),
      .rst      (rst),
      .leaf     (released),
      .root     (root_pulse),
      .any_coll (coll_now)
   );

   obs_p2l u_p2l (
      .clk   (clk),
      .rst   (rst),
      .pulse (root_pulse),
      .level (level_out)
   );

   always_ff @(posedge clk) begin
      if (rst) collide <= 1'b0;
      else     collide <= collide | coll_now;
   end

   AST_COLLIDE_STICKY: assert property (@(posedge clk) disable iff (rst)
      collide |=> collide) else $error("collision flag dropped"); // R7
   AST_SPLIT_COPY: assert property (@(posedge clk) disable iff (rst)
      node_out == node_in) else $error("functional copy differs"); // R1
endmodule

// File: tb/tb_obs_pulse_mux.sv
module tb_obs_pulse_mux;
   localparam int N = 4;
   localparam int CYC_LIMIT = 20000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0] node_in = '0;
   logic [N-1:0] strobe  = '0;
   logic [N-1:0] node_out;
   logic level_out, collide;

   int errors = 0;
   int checks = 0;
   int tog_cnt = 0;
   logic prev_lvl = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   obs_pulse_mux #(.N_PTS(N)) dut (
      .clk(clk), .rst(rst), .node_in(node_in), .strobe(strobe),
      .node_out(node_out), .level_out(level_out), .collide(collide)
   );

   always @(negedge clk) begin
      if (level_out !== prev_lvl) tog_cnt++;
      prev_lvl = level_out;
   end

   // {load[3:0], strobe[3:0], expected inversions, expected collide}
   localparam logic [9:0] VEC [0:6] = '{
      {4'b0001, 4'b0001, 1'b1, 1'b0},   // R2 basic release
      {4'b0000, 4'b0001, 1'b0, 1'b0},   // R3 second read empty
      {4'b0000, 4'b1111, 1'b0, 1'b0},   // R4 all cells empty
      {4'b0110, 4'b0100, 1'b1, 1'b0},   // R10 select point 2 only
      {4'b0000, 4'b0010, 1'b1, 1'b0},   // R10 point 1 still held
      {4'b1000, 4'b1000, 1'b1, 1'b0},   // R2 top point
      {4'b0011, 4'b0011, 1'b1, 1'b1}    // R7 sibling coincidence
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load(input logic [N-1:0] m);
      @(negedge clk);
      node_in = m;
      #1 check("R1", int'(node_out), int'(m));
      @(negedge clk);
      node_in = '0;
   endtask

   task automatic fire(input logic [N-1:0] m);
      @(negedge clk);
      strobe = m;
      @(negedge clk);
      strobe = '0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      settle(2);
      rst = 1'b0;
      settle(1);
   endtask

   initial begin
      int base;
      settle(3);
      rst = 1'b0;
      settle(1);
      check("R9 level", int'(level_out), 0);
      check("R9 collide", int'(collide), 0);

      foreach (VEC[k]) begin
         base = tog_cnt;
         if (VEC[k][9:6] != 0) load(VEC[k][9:6]);
         fire(VEC[k][5:2]);
         settle(5);
         check($sformatf("vec%0d R2/R3/R4/R7/R10 toggles", k), tog_cnt - base, int'(VEC[k][1]));
         check($sformatf("vec%0d R7 collide", k), int'(collide), int'(VEC[k][0]));
      end
      settle(3);
      check("R7 sticky", int'(collide), 1);

      // R9: reset clears collide, level and stored pulses
      load(4'b0100);
      do_reset();
      check("R9 collide cleared", int'(collide), 0);
      check("R9 level cleared", int'(level_out), 0);
      base = tog_cnt;
      fire(4'b0100);
      settle(5);
      check("R9 stored cleared", tog_cnt - base, 0);

      // R5: two arrivals, one release
      load(4'b1000);
      load(4'b1000);
      base = tog_cnt;
      fire(4'b1000);
      settle(5);
      check("R5 one toggle", tog_cnt - base, 1);
      base = tog_cnt;
      fire(4'b1000);
      settle(5);
      check("R5 then empty", tog_cnt - base, 0);

      // R6: arrival and strobe in the same cycle
      load(4'b0001);
      base = tog_cnt;
      @(negedge clk);
      node_in = 4'b0001;
      strobe  = 4'b0001;
      @(negedge clk);
      node_in = '0;
      strobe  = '0;
      settle(5);
      check("R6 first release", tog_cnt - base, 1);
      base = tog_cnt;
      fire(4'b0001);
      settle(5);
      check("R6 kept arrival", tog_cnt - base, 1);

      // R8: same points released one cycle apart
      load(4'b0011);
      base = tog_cnt;
      fire(4'b0001);
      fire(4'b0010);
      settle(5);
      check("R8 two toggles", tog_cnt - base, 2);
      check("R8 no collide", int'(collide), 0);

      // R7: coincidence at second tree level
      load(4'b0101);
      base = tog_cnt;
      fire(4'b0101);
      settle(5);
      check("R7 level2 one toggle", tog_cnt - base, 1);
      check("R7 level2 collide", int'(collide), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (CYC_LIMIT) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule